// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page mappings for 4 KiB pages. Every lookup compares the virtual page number of the request against all valid slots in parallel. On a match, the registered response carries the physical page number joined to the untouched 12-bit page offset. If nothing matches, the response raises a fault flag and returns no address, so the requester can trap before it commits any result.

Each slot keeps two status bits that lookups update. A used bit is set by every translation through the slot. A modified bit is set by every write translation. A bulk command clears all used bits, which gives an aging scheme.

A handler services a fault through a refill port. It writes a new mapping into the slot that the block recommends on `fill_slot`, and then retries the faulting access. The recommended slot is chosen in this order: an empty slot first, then a slot whose used bit is clear, then a rotating pointer. A global invalidate empties the whole buffer.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every slot is empty, `rs_valid`, `rs_fault`, `rs_paddr` and `rs_dirty` are 0, and `fill_slot` is 0.
- R2: A lookup (`lk_valid`=1) whose page number `lk_vaddr[VA_W-1:12]` matches a valid slot produces, on the next clock edge, `rs_valid`=1 and `rs_fault`=0. In that response `rs_paddr` = {slot physical page, `lk_vaddr[11:0]`}.
- R3: A lookup that matches no valid slot produces, on the next edge, `rs_valid`=1, `rs_fault`=1, `rs_paddr`=0 and `rs_dirty`=0. It changes no slot state.
- R4: A hitting lookup sets the used bit of the matched slot. This is visible because that slot is no longer recommended by the used-bit rule of R7.
- R5: `ref_clear`=1 clears every used bit in one cycle. A slot hit by a lookup in the same cycle keeps its used bit set.
- R6: A hitting write lookup (`lk_write`=1) sets the slot's modified bit, and a hitting read leaves it unchanged. `rs_dirty` reports the modified bit as it stands after the access. A refill clears the modified and used bits of the slot it writes.
- R7: `fill_slot` (slot index, 0-based) names the lowest-index empty slot if any slot is empty. Otherwise it names the lowest-index valid slot with a clear used bit. Otherwise it names a rotating pointer that starts at 0 and advances by one, modulo the slot count, each time a refill lands on the slot it named.
- R8: A refill (`fill_valid`=1) whose `fill_vpn` already matches a valid slot overwrites that slot instead of the recommended slot, and leaves the rotating pointer unchanged. No page is ever held twice.
- R9: `inv_all`=1 empties every slot in one cycle and overrides a refill in the same cycle. A lookup in the same cycle is answered from the contents held before the invalidate.
- R10: A lookup in the same cycle as a refill of the same page is answered from the contents held before the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | VA_W (32) | Virtual address to translate |
| rs_valid | output | 1 | Registered response present |
| rs_fault | output | 1 | Response is a translation miss |
| rs_paddr | output | PA_W (32) | Translated physical address (0 on a miss) |
| rs_dirty | output | 1 | Modified bit of the matched slot after the access |
| fill_valid | input | 1 | Refill request this cycle |
| fill_vpn | input | VA_W-12 (20) | Virtual page number to load |
| fill_ppn | input | PA_W-12 (20) | Physical page number to load |
| fill_slot | output | $clog2(SLOTS) (3) | Slot the next refill will use |
| ref_clear | input | 1 | Clear all used bits |
| inv_all | input | 1 | Empty all slots |

## Verification
A corrupted tag or physical page shows at the next lookup of that page as a wrong address or a false fault, one cycle after the request. A used bit that is wrong does not change any translation. It shows only as a wrong `fill_slot`, which the bench compares against its model every cycle, so such an error appears as soon as the recommendation depends on that bit. A modified bit that is lost or set falsely shows in `rs_dirty` on the next hit to the slot. An error in the rotating pointer stays hidden until every slot is valid and used, and the bench deliberately forces that condition.

// File: rtl/xlat_pkg.sv
// Shared definitions for the translation buffer.
// Assumes pages of 1 << PAGE_BITS bytes for every instance.
package xlat_pkg;
    localparam int PAGE_BITS = 12;

    // Which rule produced the recommended refill slot.
    typedef enum logic [1:0] {
        VIC_FREE   = 2'd0,
        VIC_COLD   = 2'd1,
        VIC_ROTATE = 2'd2
    } vic_rule_e;
endpackage

// File: rtl/xlat_match.sv
// Parallel page-number comparator: one equality compare per slot,
// gated by that slot's valid bit. Purely combinational.
// Assumes the caller keeps at most one valid copy of any page number.
module xlat_match #(
    parameter int SLOTS = 8,
    parameter int VPN_W = 20
) (
    input  logic [SLOTS-1:0]            valid,
    input  logic [SLOTS-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]            key,
    output logic [SLOTS-1:0]            hit
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        // Compare one slot's tag against the key.
        assign hit[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/xlat_victim.sv
// Refill slot chooser: lowest empty slot, else lowest valid slot with
// a clear used bit, else a rotating pointer. The pointer moves only
// when the caller reports that a refill used the rotation choice.
// Assumes SLOTS >= 2.
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] valid,
    input  logic [SLOTS-1:0] refd,
    input  logic             advance,
    output logic [IDX_W-1:0] slot,
    output vic_rule_e        rule
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx, cold_idx;
    logic             have_free, have_cold;

    // Priority search, scanning downward so the lowest index wins.
    always_comb begin
        free_idx  = '0;
        cold_idx  = '0;
        have_free = 1'b0;
        have_cold = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
            if (valid[i] && !refd[i]) begin
                have_cold = 1'b1;
                cold_idx  = IDX_W'(i);
            end
        end
    end

    // Select among the three rules in priority order.
    always_comb begin
        if (have_free) begin
            slot = free_idx;
            rule = VIC_FREE;
        end else if (have_cold) begin
            slot = cold_idx;
            rule = VIC_COLD;
        end else begin
            slot = rr_q;
            rule = VIC_ROTATE;
        end
    end

    // Rotating pointer, advanced when a refill took the rotation slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= (rr_q == IDX_W'(SLOTS - 1)) ? '0 : rr_q + IDX_W'(1);
        end
    end

    // R7: an empty slot, if any exists, is always the one recommended.
    assert_free_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (~valid != '0) |-> !valid[slot]);
endmodule

// File: rtl/xlat_store.sv
// Slot storage: valid, tag, physical page, used and modified bits.
// Per-slot priority: invalidate, then refill, then access updates.
// Assumes fill_we has at most one bit set.
module xlat_store #(
    parameter int SLOTS = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inv_all,
    input  logic                        ref_clear,
    input  logic [SLOTS-1:0]            hit_en,
    input  logic                        acc_write,
    input  logic [SLOTS-1:0]            fill_we,
    input  logic [VPN_W-1:0]            fill_vpn,
    input  logic [PPN_W-1:0]            fill_ppn,
    output logic [SLOTS-1:0]            valid,
    output logic [SLOTS-1:0][VPN_W-1:0] tags,
    output logic [SLOTS-1:0][PPN_W-1:0] ppns,
    output logic [SLOTS-1:0]            refd,
    output logic [SLOTS-1:0]            dirty
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Valid and status bits of one slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[g] <= 1'b0;
                refd[g]  <= 1'b0;
                dirty[g] <= 1'b0;
            end else if (inv_all) begin
                valid[g] <= 1'b0;
            end else if (fill_we[g]) begin
                valid[g] <= 1'b1;
                refd[g]  <= 1'b0;
                dirty[g] <= 1'b0;
            end else begin
                if (hit_en[g]) begin
                    refd[g] <= 1'b1;
                end else if (ref_clear) begin
                    refd[g] <= 1'b0;
                end
                if (hit_en[g] && acc_write) begin
                    dirty[g] <= 1'b1;
                end
            end
        end

        // Mapping payload of one slot, loaded only by a refill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tags[g] <= '0;
                ppns[g] <= '0;
            end else if (fill_we[g] && !inv_all) begin
                tags[g] <= fill_vpn;
                ppns[g] <= fill_ppn;
            end
        end
    end

    // R9: a global invalidate leaves no slot valid.
    assert_inv_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid == '0));

    // R5: a bulk clear with no competing hit or refill zeroes all used bits.
    assert_ref_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_clear && !inv_all && (hit_en == '0) && (fill_we == '0)) |=> (refd == '0));
endmodule

// File: rtl/xlat_tlb.sv
// Fully associative translation buffer top. Lookups are compared
// against all slots at once and answered with registered outputs one
// edge later. Misses raise rs_fault and change nothing. Refills are
// written to the recommended slot, or to the slot already holding the
// same page. Assumes 4 KiB pages and VA_W, PA_W > PAGE_BITS.
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    localparam int VPN_W = VA_W - PAGE_BITS,
    localparam int PPN_W = PA_W - PAGE_BITS,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             rs_valid,
    output logic             rs_fault,
    output logic [PA_W-1:0]  rs_paddr,
    output logic             rs_dirty,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    output logic [IDX_W-1:0] fill_slot,
    input  logic             ref_clear,
    input  logic             inv_all
);
    logic [SLOTS-1:0]            valid, refd, dirty;
    logic [SLOTS-1:0][VPN_W-1:0] tags;
    logic [SLOTS-1:0][PPN_W-1:0] ppns;
    logic [SLOTS-1:0]            hit_vec, dup_vec, hit_en, fill_we, fill_tgt;
    logic [PPN_W-1:0]            hit_ppn;
    logic                        hit_dirty, lk_hit, advance;
    vic_rule_e                   vic_rule;

    xlat_match #(.SLOTS(SLOTS), .VPN_W(VPN_W)) u_lk_match (
        .valid (valid),
        .tags  (tags),
        .key   (lk_vaddr[VA_W-1:PAGE_BITS]),
        .hit   (hit_vec)
    );

    xlat_match #(.SLOTS(SLOTS), .VPN_W(VPN_W)) u_fill_match (
        .valid (valid),
        .tags  (tags),
        .key   (fill_vpn),
        .hit   (dup_vec)
    );

    xlat_victim #(.SLOTS(SLOTS)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (valid),
        .refd    (refd),
        .advance (advance),
        .slot    (fill_slot),
        .rule    (vic_rule)
    );

    xlat_store #(.SLOTS(SLOTS), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_all   (inv_all),
        .ref_clear (ref_clear),
        .hit_en    (hit_en),
        .acc_write (lk_write),
        .fill_we   (fill_we),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .valid     (valid),
        .tags      (tags),
        .ppns      (ppns),
        .refd      (refd),
        .dirty     (dirty)
    );

    // Gate the match vector with the request strobe.
    assign hit_en = lk_valid ? hit_vec : '0;
    assign lk_hit = |hit_en;

    // Select the matched slot's physical page and modified bit.
    always_comb begin
        hit_ppn   = '0;
        hit_dirty = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (hit_vec[i]) begin
                hit_ppn   = hit_ppn | ppns[i];
                hit_dirty = hit_dirty | dirty[i];
            end
        end
    end

    // Route a refill to the existing copy of the page, else to the recommended slot.
    always_comb begin
        fill_tgt = (dup_vec != '0) ? dup_vec : (SLOTS'(1) << fill_slot);
        fill_we  = (fill_valid && !inv_all) ? fill_tgt : '0;
        advance  = fill_valid && !inv_all && (dup_vec == '0) && (vic_rule == VIC_ROTATE);
    end

    // Register the response: translation on a hit, fault on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_fault <= 1'b0;
            rs_paddr <= '0;
            rs_dirty <= 1'b0;
        end else begin
            rs_valid <= lk_valid;
            rs_fault <= lk_valid && !lk_hit;
            rs_paddr <= lk_hit ? {hit_ppn, lk_vaddr[PAGE_BITS-1:0]} : '0;
            rs_dirty <= lk_hit && (hit_dirty || lk_write);
        end
    end

    // R8: no page is held in two slots, so at most one slot matches.
    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R3: a fault is only ever reported inside a response.
    assert_fault_in_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rs_fault |-> rs_valid);

    // R2: a successful translation keeps the offset of the request.
    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rs_fault || rs_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0])));
endmodule

// File: tb/sim_xlat_tlb.sv
module sim_xlat_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0;
    logic [31:0] lk_vaddr = '0;
    logic        rs_valid, rs_fault, rs_dirty;
    logic [31:0] rs_paddr;
    logic        fill_valid = 0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic [2:0]  fill_slot;
    logic        ref_clear = 0, inv_all = 0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state
    bit        m_valid[N];
    bit        m_ref[N];
    bit        m_dirty[N];
    bit [19:0] m_tag[N];
    bit [19:0] m_ppn[N];
    int        m_rr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_tlb u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .rs_valid(rs_valid), .rs_fault(rs_fault), .rs_paddr(rs_paddr), .rs_dirty(rs_dirty),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_slot(fill_slot), .ref_clear(ref_clear), .inv_all(inv_all)
    );

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic int find_m(bit [19:0] vpn);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    // rule: 0 free, 1 cold, 2 rotate
    task automatic victim_m(output int slot, output int rule);
        for (int i = 0; i < N; i++)
            if (!m_valid[i]) begin slot = i; rule = 0; return; end
        for (int i = 0; i < N; i++)
            if (!m_ref[i]) begin slot = i; rule = 1; return; end
        slot = m_rr; rule = 2;
    endtask

    task automatic idle();
        lk_valid = 0; lk_write = 0; fill_valid = 0; ref_clear = 0; inv_all = 0;
    endtask

    // One clock with the inputs already driven; checks slot and response.
    task automatic step(string tag);
        int vs, vr, h, d, t;
        bit ef, ed;
        bit [31:0] ep;
        victim_m(vs, vr);
        chk($sformatf("R7 fill_slot [%s]", tag), fill_slot, vs);
        h = lk_valid ? find_m(lk_vaddr[31:12]) : -1;
        ef = lk_valid && (h < 0);
        ep = (h >= 0) ? {m_ppn[h], lk_vaddr[11:0]} : 32'h0;
        ed = (h >= 0) ? (m_dirty[h] | lk_write) : 1'b0;
        d = find_m(fill_vpn);
        @(posedge clk);
        if (inv_all) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (i == h) begin
                    m_ref[i] = 1;
                    if (lk_write) m_dirty[i] = 1;
                end else if (ref_clear) m_ref[i] = 0;
            end
            if (fill_valid) begin
                t = (d >= 0) ? d : vs;
                if (d < 0 && vr == 2) m_rr = (m_rr + 1) % N;
                m_valid[t] = 1; m_tag[t] = fill_vpn; m_ppn[t] = fill_ppn;
                m_ref[t] = 0; m_dirty[t] = 0;
            end
        end
        @(negedge clk);
        chk($sformatf("R2 rs_valid [%s]", tag), rs_valid, lk_valid);
        if (lk_valid) begin
            chk($sformatf("%s rs_fault [%s]", ef ? "R3" : "R2", tag), rs_fault, ef);
            chk($sformatf("%s rs_paddr [%s]", ef ? "R3" : "R2", tag), rs_paddr, ep);
            chk($sformatf("R6 rs_dirty [%s]", tag), rs_dirty, ed);
        end
        idle();
    endtask

    task automatic look(bit [19:0] vpn, bit [11:0] off, bit wr, string tag);
        lk_valid = 1; lk_write = wr; lk_vaddr = {vpn, off};
        step(tag);
    endtask

    task automatic fill(bit [19:0] vpn, bit [19:0] ppn, string tag);
        fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn;
        step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 rs_valid", rs_valid, 0);
        chk("R1 rs_fault", rs_fault, 0);
        chk("R1 rs_paddr", rs_paddr, 0);
        chk("R1 rs_dirty", rs_dirty, 0);
        chk("R1 fill_slot", fill_slot, 0);
        look(20'h10, 12'h123, 0, "R1 empty miss");

        for (int i = 0; i < N; i++) fill(20'h10 + 20'(i), 20'h100 + 20'(i), "R7 fill empty");
        look(20'h12, 12'hfff, 0, "R2 hit");
        look(20'h13, 12'h004, 1, "R6 write");
        look(20'h13, 12'h008, 0, "R6 read after write");
        look(20'h55, 12'h001, 0, "R3 miss");
        chk("R4 cold slot after miss", fill_slot, 0);
        look(20'h10, 12'h0, 0, "R4 use0");
        look(20'h11, 12'h0, 0, "R4 use1");
        chk("R4 used slots skipped", fill_slot, 4);
        ref_clear = 1;
        look(20'h10, 12'h0, 0, "R5 clear with hit");
        chk("R5 hit keeps used bit", fill_slot, 1);
        for (int i = 0; i < N; i++) look(20'h10 + 20'(i), 12'h0, 0, "R4 use all");
        chk("R7 rotate start", fill_slot, 0);
        fill(20'h20, 20'h200, "R7 rotate fill");
        look(20'h20, 12'h0, 0, "R7 use new");
        chk("R7 rotate advanced", fill_slot, 1);
        fill(20'h12, 20'h999, "R8 dup refill");
        look(20'h12, 12'habc, 0, "R8 overwritten mapping");
        look(20'h13, 12'h0, 0, "R6 still dirty");
        fill(20'h13, 20'h333, "R6 refill");
        look(20'h13, 12'h0, 0, "R6 refill clears dirty");
        lk_valid = 1; lk_vaddr = {20'h14, 12'h55};
        fill_valid = 1; fill_vpn = 20'h14; fill_ppn = 20'h444;
        step("R10 lookup vs refill");
        look(20'h14, 12'h55, 0, "R10 new mapping");
        lk_valid = 1; lk_vaddr = {20'h15, 12'h77};
        fill_valid = 1; fill_vpn = 20'h30; fill_ppn = 20'h300;
        inv_all = 1;
        step("R9 invalidate");
        look(20'h30, 12'h0, 0, "R9 refill dropped");
        look(20'h15, 12'h0, 0, "R9 entry gone");
        chk("R9 all empty", fill_slot, 0);

        // Constrained random mix
        for (int c = 0; c < 1500; c++) begin
            int r;
            r = $urandom_range(0, 99);
            lk_valid = (r < 70);
            lk_write = $urandom_range(0, 1);
            lk_vaddr = {20'h10 + 20'($urandom_range(0, 11)), 12'($urandom)};
            fill_valid = ($urandom_range(0, 99) < 30);
            fill_vpn = 20'h10 + 20'($urandom_range(0, 11));
            fill_ppn = 20'($urandom);
            ref_clear = ($urandom_range(0, 99) < 5);
            inv_all = ($urandom_range(0, 199) == 0);
            step("random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule